// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Unit

This unit sits beside a five-stage in-order pipeline and settles its data hazards with pure combinational logic. For the instruction now in execute, it compares the two source register numbers with the destination numbers held one stage ahead (execute/memory boundary) and two stages ahead (memory/writeback boundary). From the result it drives the select codes of the two ALU operand multiplexers, so that a result still travelling down the pipe reaches its consumer without waiting for writeback.

A second path covers the decode-stage register read. When writeback stores a register in the same cycle that decode reads it, a bypass flag tells the read port to return the value being written. A third path finds the one case that bypassing cannot cover: a load in execute whose destination is a source of the instruction in decode. The unit then freezes the program counter and the fetch/decode register for that cycle and zeroes the control word going into execute. This inserts exactly one bubble, and the dependent instruction gets the loaded value from the memory/writeback stage one cycle later.

No clock is used: every output is a function of the current inputs only. The multiplexers, the register file and the pipeline registers are outside the block.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When no producer matches a source, that operand's select is 2'b00 (register file value).
- R2: When the execute/memory producer has its write flag set, a nonzero destination, and a destination equal to the operand's source, the select is 2'b10.
- R3: When only the memory/writeback producer matches (write flag set, nonzero destination, equal number), the select is 2'b01.
- R4: When both producers match the same source, the select is 2'b10, because the newer result wins.
- R5: A producer whose write flag is clear, or whose destination is register 0, never causes forwarding or a decode bypass.
- R6: When writeback has its write flag set, a nonzero destination, and a destination equal to a decode source, that port's decode bypass flag is 1. Otherwise it is 0.
- R7: When the execute instruction is a load and its Rt equals the decode Rs or Rt, the unit drives pc_we=0, ifid_we=0 and ctrl_zero=1 in that same cycle.
- R8: When there is no load-use match, pc_we=1, ifid_we=1 and ctrl_zero=0. Stall outputs do not depend on the forwarding inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs | input | RAW | Rs of instruction in execute |
| ex_rt | input | RAW | Rt of instruction in execute (also load destination) |
| ex_is_load | input | 1 | Execute instruction reads data memory |
| exm_rd | input | RAW | Destination at execute/memory boundary |
| exm_wr | input | 1 | Register write flag at execute/memory boundary |
| mwb_rd | input | RAW | Destination at memory/writeback boundary |
| mwb_wr | input | 1 | Register write flag at memory/writeback boundary |
| id_rs | input | RAW | Rs of instruction in decode |
| id_rt | input | RAW | Rt of instruction in decode |
| sel_a | output | 2 | Operand A source select (00 rf, 10 exm, 01 mwb) |
| sel_b | output | 2 | Operand B source select (same code) |
| rfbyp_a | output | 1 | Decode Rs read returns the value being written |
| rfbyp_b | output | 1 | Decode Rt read returns the value being written |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| ctrl_zero | output | 1 | Zero the control word entering execute |

## Verification
All outputs are combinational, so each result is due in the same cycle as the inputs that cause it, with zero register delay. The bench applies a new input set just after each rising edge. It samples on the following falling edge, after the logic has settled and before the next change, and it compares every output with a behavioural model on every clock. Directed vectors cover both-producer priority, register 0 and the clear write flag, and a load that matches on Rs and on Rt. A long run then draws register numbers from a small set so that matches are frequent.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
    typedef enum logic [1:0] {
        SRC_RF  = 2'b00,
        SRC_MWB = 2'b01,
        SRC_EXM = 2'b10
    } opsrc_e;
endpackage

// File: rtl/opnd_fwd_sel.sv
module opnd_fwd_sel
    import hazard_pkg::*;
#(
    parameter int RAW = 5
) (
    input  logic [RAW-1:0] src,
    input  logic [RAW-1:0] exm_rd,
    input  logic           exm_wr,
    input  logic [RAW-1:0] mwb_rd,
    input  logic           mwb_wr,
    output logic [1:0]     sel
);
    localparam logic [RAW-1:0] ZERO_REG = '0;

    logic hit_exm;
    logic hit_mwb;
    opsrc_e choice;

    always_comb begin
        hit_exm = exm_wr && (exm_rd != ZERO_REG) && (exm_rd == src);
        hit_mwb = mwb_wr && (mwb_rd != ZERO_REG) && (mwb_rd == src);
        unique case ({hit_exm, hit_mwb})
            2'b10, 2'b11: choice = SRC_EXM;
            2'b01:        choice = SRC_MWB;
            default:      choice = SRC_RF;
        endcase
        sel = choice;
    end
endmodule

// File: rtl/rf_wr_bypass.sv
module rf_wr_bypass #(
    parameter int RAW = 5
) (
    input  logic [RAW-1:0] rd_idx,
    input  logic [RAW-1:0] wr_idx,
    input  logic           wr_en,
    output logic           byp
);
    localparam logic [RAW-1:0] ZERO_REG = '0;
    always_comb byp = wr_en && (wr_idx != ZERO_REG) && (wr_idx == rd_idx);
endmodule

// File: rtl/loaduse_detect.sv
module loaduse_detect #(
    parameter int RAW = 5
) (
    input  logic           ex_is_load,
    input  logic [RAW-1:0] ex_rt,
    input  logic [RAW-1:0] id_rs,
    input  logic [RAW-1:0] id_rt,
    output logic           pc_we,
    output logic           ifid_we,
    output logic           ctrl_zero
);
    logic hold;
    always_comb begin
        hold      = ex_is_load && ((ex_rt == id_rs) || (ex_rt == id_rt));
        pc_we     = !hold;
        ifid_we   = !hold;
        ctrl_zero = hold;
    end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit #(
    parameter int RAW = 5
) (
    input  logic [RAW-1:0] ex_rs,
    input  logic [RAW-1:0] ex_rt,
    input  logic           ex_is_load,
    input  logic [RAW-1:0] exm_rd,
    input  logic           exm_wr,
    input  logic [RAW-1:0] mwb_rd,
    input  logic           mwb_wr,
    input  logic [RAW-1:0] id_rs,
    input  logic [RAW-1:0] id_rt,
    output logic [1:0]     sel_a,
    output logic [1:0]     sel_b,
    output logic           rfbyp_a,
    output logic           rfbyp_b,
    output logic           pc_we,
    output logic           ifid_we,
    output logic           ctrl_zero
);
    localparam int NOPND = 2;

    logic [RAW-1:0] ex_src [NOPND];
    logic [RAW-1:0] id_src [NOPND];
    logic [1:0]     sel_v  [NOPND];
    logic           byp_v  [NOPND];

    always_comb begin
        ex_src[0] = ex_rs;
        ex_src[1] = ex_rt;
        id_src[0] = id_rs;
        id_src[1] = id_rt;
    end

    for (genvar g = 0; g < NOPND; g++) begin : g_opnd
        opnd_fwd_sel #(.RAW(RAW)) i_sel (
            .src    (ex_src[g]),
            .exm_rd (exm_rd),
            .exm_wr (exm_wr),
            .mwb_rd (mwb_rd),
            .mwb_wr (mwb_wr),
            .sel    (sel_v[g])
        );
        rf_wr_bypass #(.RAW(RAW)) i_byp (
            .rd_idx (id_src[g]),
            .wr_idx (mwb_rd),
            .wr_en  (mwb_wr),
            .byp    (byp_v[g])
        );
    end

    always_comb begin
        sel_a   = sel_v[0];
        sel_b   = sel_v[1];
        rfbyp_a = byp_v[0];
        rfbyp_b = byp_v[1];
    end

    loaduse_detect #(.RAW(RAW)) i_lu (
        .ex_is_load (ex_is_load),
        .ex_rt      (ex_rt),
        .id_rs      (id_rs),
        .id_rt      (id_rt),
        .pc_we      (pc_we),
        .ifid_we    (ifid_we),
        .ctrl_zero  (ctrl_zero)
    );
endmodule

// File: rtl/hazard_fwd_chk.sv
module hazard_fwd_chk #(
    parameter int RAW = 5
) (
    input logic [RAW-1:0] ex_rs,
    input logic [RAW-1:0] ex_rt,
    input logic           ex_is_load,
    input logic [RAW-1:0] exm_rd,
    input logic           exm_wr,
    input logic [RAW-1:0] mwb_rd,
    input logic           mwb_wr,
    input logic [RAW-1:0] id_rs,
    input logic [RAW-1:0] id_rt,
    input logic [1:0]     sel_a,
    input logic [1:0]     sel_b,
    input logic           rfbyp_a,
    input logic           rfbyp_b,
    input logic           pc_we,
    input logic           ifid_we,
    input logic           ctrl_zero
);
    logic known;
    always_comb begin
        known = !$isunknown({ex_rs, ex_rt, ex_is_load, exm_rd, exm_wr, mwb_rd, mwb_wr,
                             id_rs, id_rt, sel_a, sel_b, rfbyp_a, rfbyp_b,
                             pc_we, ifid_we, ctrl_zero});
        if (known) begin
            a_r1_legal_code: assert (sel_a != 2'b11 && sel_b != 2'b11)
                else $error("R1 illegal select");
            a_r2_exm_source: assert (sel_a != 2'b10 || (exm_wr && exm_rd == ex_rs && exm_rd != '0))
                else $error("R2 exm select without match");
            a_r3_mwb_source: assert (sel_b != 2'b01 || (mwb_wr && mwb_rd == ex_rt && mwb_rd != '0))
                else $error("R3 mwb select without match");
            a_r4_newer_wins: assert (!(exm_wr && exm_rd != '0 && exm_rd == ex_rs) || sel_a == 2'b10)
                else $error("R4 newer producer not chosen");
            a_r5_no_write: assert (exm_wr || mwb_wr || (sel_a == 2'b00 && sel_b == 2'b00 && !rfbyp_a && !rfbyp_b))
                else $error("R5 forward with write flags clear");
            a_r6_byp_src: assert (!rfbyp_b || (mwb_wr && mwb_rd == id_rt))
                else $error("R6 decode bypass without write");
            a_r7_stall_all: assert (ctrl_zero == !pc_we && ctrl_zero == !ifid_we)
                else $error("R7 stall controls disagree");
            a_r8_no_load_no_stall: assert (ex_is_load || pc_we)
                else $error("R8 stall without load");
        end
    end
endmodule

bind hazard_fwd_unit hazard_fwd_chk #(.RAW(RAW)) i_chk (.*);

// File: tb/test_hazard_fwd_unit.sv
module test_hazard_fwd_unit;
    localparam int RAW = 5;
    localparam time CLK_PERIOD = 10ns;
    localparam int RAND_CYCLES = 3000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic [RAW-1:0] ex_rs = '0, ex_rt = '0, exm_rd = '0, mwb_rd = '0, id_rs = '0, id_rt = '0;
    logic ex_is_load = 1'b0, exm_wr = 1'b0, mwb_wr = 1'b0;
    logic [1:0] sel_a, sel_b;
    logic rfbyp_a, rfbyp_b, pc_we, ifid_we, ctrl_zero;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    hazard_fwd_unit #(.RAW(RAW)) i_hazard_fwd_unit (.*);

    function automatic int exp_sel(int src);
        bit e = exm_wr && exm_rd != 0 && int'(exm_rd) == src;
        bit m = mwb_wr && mwb_rd != 0 && int'(mwb_rd) == src;
        if (e) return 2;
        if (m) return 1;
        return 0;
    endfunction

    function automatic string sel_tag(int src);
        bit e = exm_wr && exm_rd != 0 && int'(exm_rd) == src;
        bit m = mwb_wr && mwb_rd != 0 && int'(mwb_rd) == src;
        if (e && m) return "R4";
        if (e) return "R2";
        if (m) return "R3";
        if (int'(exm_rd) == src || int'(mwb_rd) == src) return "R5";
        return "R1";
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        bit byp_a_e, byp_b_e, stall_e;
        byp_a_e = mwb_wr && mwb_rd != 0 && mwb_rd == id_rs;
        byp_b_e = mwb_wr && mwb_rd != 0 && mwb_rd == id_rt;
        stall_e = ex_is_load && (ex_rt == id_rs || ex_rt == id_rt);
        check(sel_tag(int'(ex_rs)), "sel_a", int'(sel_a), exp_sel(int'(ex_rs)));
        check(sel_tag(int'(ex_rt)), "sel_b", int'(sel_b), exp_sel(int'(ex_rt)));
        check("R6", "rfbyp_a", int'(rfbyp_a), int'(byp_a_e));
        check("R6", "rfbyp_b", int'(rfbyp_b), int'(byp_b_e));
        check(stall_e ? "R7" : "R8", "pc_we", int'(pc_we), int'(!stall_e));
        check(stall_e ? "R7" : "R8", "ifid_we", int'(ifid_we), int'(!stall_e));
        check(stall_e ? "R7" : "R8", "ctrl_zero", int'(ctrl_zero), int'(stall_e));
    endtask

    // sample every falling edge: inputs were driven after the rising edge
    always @(negedge clk) if (rst_n && !done) compare_all();

    task automatic apply(int rs, int rt, bit ld, int erd, bit ew, int mrd, bit mw, int irs, int irt);
        @(posedge clk);
        #1;
        ex_rs = RAW'(rs); ex_rt = RAW'(rt); ex_is_load = ld;
        exm_rd = RAW'(erd); exm_wr = ew; mwb_rd = RAW'(mrd); mwb_wr = mw;
        id_rs = RAW'(irs); id_rt = RAW'(irt);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // reset-state inputs: all zero, R1 and R8 quiet outputs
        @(negedge clk);
        apply(1, 2, 0, 3, 1, 4, 1, 5, 6);     // R1 no match
        apply(3, 2, 0, 3, 1, 4, 1, 5, 6);     // R2 exm on rs
        apply(1, 4, 0, 3, 1, 4, 1, 5, 6);     // R3 mwb on rt
        apply(7, 7, 0, 7, 1, 7, 1, 5, 6);     // R4 both match both ports
        apply(0, 0, 0, 0, 1, 0, 1, 0, 0);     // R5 register 0
        apply(9, 9, 0, 9, 0, 9, 0, 9, 9);     // R5 write flags clear
        apply(1, 2, 0, 3, 0, 8, 1, 8, 8);     // R6 decode bypass both
        apply(1, 2, 0, 3, 0, 0, 1, 0, 0);     // R6 register 0 not bypassed
        apply(1, 5, 1, 3, 0, 4, 0, 5, 6);     // R7 load rt == id rs
        apply(1, 6, 1, 3, 0, 4, 0, 5, 6);     // R7 load rt == id rt
        apply(1, 6, 0, 3, 0, 4, 0, 5, 6);     // R8 same regs, not a load
        apply(6, 6, 1, 6, 1, 6, 1, 5, 7);     // R8 load, no decode match
        for (int i = 0; i < RAND_CYCLES; i++) begin
            apply($urandom_range(0, 3), $urandom_range(0, 3), 1'($urandom),
                  $urandom_range(0, 3), 1'($urandom), $urandom_range(0, 3), 1'($urandom),
                  $urandom_range(0, 3), $urandom_range(0, 3));
        end
        @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule